// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This block is a purely combinational integer arithmetic stage for a 32-bit datapath. A 3-bit operation code selects one of six functions on two operands: add or subtract, each in a trapping (signed) form and a wrapping (unsigned) form, and a less-than compare in signed or unsigned form. All six share one adder. For subtraction and comparison the second operand goes into the adder inverted, with a carry-in of one.

The unit drives three outputs. The first is the result word. The second is the carry out of the top adder bit. The third is a request line that asks the surrounding pipeline to take an overflow exception. Only the trapping add and subtract can raise that request. The wrapping forms silently return the low 32 bits. A compare returns a single outcome bit, zero-extended to the full word. The unit holds no state. Registering the operands or the outputs is left to the pipeline that instantiates it.

Top module: `int_addsub_cmp`

## Requirements
- R1: Codes 3'b000 (trapping add) and 3'b001 (wrapping add) return (A + B) modulo 2^32 on `result_o`.
- R2: Codes 3'b010 (trapping subtract) and 3'b011 (wrapping subtract) return (A - B) modulo 2^32 on `result_o`.
- R3: For the two add codes `carry_o` is the carry out of bit 31 of A + B. For the codes that subtract (3'b010 to 3'b101) `carry_o` is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R4: Code 3'b000 raises `ovf_exc_o` exactly when A and B have the same sign and the sum's sign differs from theirs. Operands of different signs never raise it.
- R5: Code 3'b010 raises `ovf_exc_o` exactly when A and B differ in sign and the difference's sign differs from the sign of A.
- R6: Codes 3'b001, 3'b011, 3'b100 and 3'b101 never raise `ovf_exc_o`, whatever the operands.
- R7: Code 3'b100 returns 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise. Bits 31:1 are zero. The answer stays correct when A - B overflows.
- R8: Code 3'b101 returns 1 in bit 0 when A < B as unsigned numbers, and 0 otherwise. Bits 31:1 are zero. With A = -4 and B = 10, the signed compare gives 1 and the unsigned compare gives 0.
- R9: Codes 3'b110 and 3'b111 return a zero result, `carry_o` = 0 and `ovf_exc_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, subtracted from or compared against the first |
| result_o | output | 32 | Sum, difference or zero-extended compare outcome |
| carry_o | output | 1 | Adder carry out of the top bit; 1 means no borrow on the subtracting codes |
| ovf_exc_o | output | 1 | Signed-overflow exception request |

## Verification
The unit has no state. Any fault appears on the outputs in the same evaluation as the stimulus that triggers it. The adder-inverse path is shared, so a slip in inversion or carry-in shows up at once: differences come out off by one, and the borrow flag sits on the wrong side of A = B. A misplaced overflow term shows up only on operand pairs that sit on the sign boundary. Typical cases are the most positive value plus one, and the most negative value minus one. It also shows up on mixed-sign compares, where the signed and unsigned answers must differ. The directed vectors concentrate on those pairs. Each vector's expected values come from 64-bit arithmetic in the bench.

// File: rtl/int_addsub_cmp.sv
module int_addsub_cmp #(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         ovf_exc_o
);
  localparam int MSB = W - 1;

  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_ADDU = 3'b001;
  localparam logic [2:0] OP_SUB  = 3'b010;
  localparam logic [2:0] OP_SUBU = 3'b011;
  localparam logic [2:0] OP_SLT  = 3'b100;
  localparam logic [2:0] OP_SLTU = 3'b101;

  logic         negate;
  logic         valid_op;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  logic         lt_s;
  logic         lt_u;

  assign negate   = (op_i == OP_SUB) || (op_i == OP_SUBU) ||
                    (op_i == OP_SLT) || (op_i == OP_SLTU);
  assign valid_op = (op_i <= OP_SLTU);
  assign b_eff    = negate ? ~b_i : b_i;

  assign {cout, sum} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, negate};

  // operands agree in sign after inversion, result disagrees
  assign ovf  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
  assign lt_s = sum[MSB] ^ ovf;
  assign lt_u = ~cout;

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_SLT:  result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(W-1){1'b0}}, lt_u};
      default: result_o = '0;
    endcase
  end

  assign carry_o   = valid_op & cout;
  assign ovf_exc_o = ovf & ((op_i == OP_ADD) || (op_i == OP_SUB));

  always_comb begin
    if (op_i == OP_ADD || op_i == OP_ADDU)
      AST_ADD_WRAP: assert (result_o == W'(a_i + b_i)); // R1
    if (op_i == OP_SUB || op_i == OP_SUBU)
      AST_SUB_WRAP: assert (result_o == W'(a_i - b_i)); // R2
    if (op_i == OP_ADDU)
      AST_ADD_CARRY: assert (carry_o == (({1'b0, a_i} + {1'b0, b_i}) >> W)); // R3
    if (negate)
      AST_NO_BORROW: assert (carry_o == (a_i >= b_i)); // R3
    if (op_i == OP_ADD && a_i[MSB] != b_i[MSB])
      AST_MIXED_ADD_SAFE: assert (!ovf_exc_o); // R4
    if (op_i == OP_SUB && a_i[MSB] == b_i[MSB])
      AST_SAME_SUB_SAFE: assert (!ovf_exc_o); // R5
    if (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_SLT || op_i == OP_SLTU)
      AST_NO_OVERFLOW: assert (!ovf_exc_o); // R6
    if (op_i == OP_SLT)
      AST_SLT_SIGNED: assert (result_o == W'($signed(a_i) < $signed(b_i))); // R7
    if (op_i == OP_SLTU)
      AST_SLT_UNSIGNED: assert (result_o == W'(a_i < b_i)); // R8
    if (!valid_op)
      AST_UNUSED_QUIET: assert (result_o == '0 && !carry_o && !ovf_exc_o); // R9
  end
endmodule

// File: tb/tb_int_addsub_cmp.sv
module tb_int_addsub_cmp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] res;
  logic        cy;
  logic        exc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_addsub_cmp dut (
    .op_i(op), .a_i(a), .b_i(b),
    .result_o(res), .carry_o(cy), .ovf_exc_o(exc)
  );

  task automatic model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] er, output logic ec, output logic ee);
    longint sx, sy, full;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    er = '0; ec = 1'b0; ee = 1'b0;
    case (o)
      3'b000, 3'b001: begin
        full = sx + sy;
        er = x + y;
        ec = ((64'(x) + 64'(y)) >> 32) != 0;
        ee = (o == 3'b000) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      3'b010, 3'b011: begin
        full = sx - sy;
        er = x - y;
        ec = (x >= y);
        ee = (o == 3'b010) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      3'b100: begin er = (sx < sy) ? 32'd1 : 32'd0; ec = (x >= y); end
      3'b101: begin er = (x < y) ? 32'd1 : 32'd0; ec = (x >= y); end
      default: ;
    endcase
  endtask

  task automatic check_bits(input string tag, input string what, input logic [31:0] got,
                            input logic [31:0] expv);
    n_checks++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, expv);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y);
    logic [31:0] er;
    logic ec, ee;
    @(negedge clk);
    op = o; a = x; b = y;
    #(CLK_PERIOD/4);
    model(o, x, y, er, ec, ee);
    check_bits(tag, "result", res, er);
    check_bits(tag, "carry", {31'd0, cy}, {31'd0, ec});
    check_bits(tag, "exception", {31'd0, exc}, {31'd0, ee});
  endtask

  task automatic t_idle;
    apply("R1 idle", 3'b000, 32'h0, 32'h0);
  endtask

  task automatic t_add;
    apply("R1", 3'b000, 32'd5, 32'd7);
    apply("R1", 3'b001, 32'hFFFF_FFFF, 32'd1);
    apply("R3", 3'b001, 32'h8000_0000, 32'h8000_0000);
    apply("R4", 3'b000, 32'h7FFF_FFFF, 32'd1);
    apply("R4", 3'b000, 32'h8000_0000, 32'hFFFF_FFFF);
    apply("R4", 3'b000, 32'h7FFF_FFFF, 32'h8000_0000);
    apply("R4", 3'b000, 32'hFFFF_FFFC, 32'd10);
  endtask

  task automatic t_sub;
    apply("R2", 3'b010, 32'd20, 32'd7);
    apply("R2", 3'b011, 32'd3, 32'd4);
    apply("R3", 3'b011, 32'd9, 32'd9);
    apply("R5", 3'b010, 32'h8000_0000, 32'd1);
    apply("R5", 3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply("R5", 3'b010, 32'h8000_0000, 32'h8000_0000);
    apply("R5", 3'b010, 32'hFFFF_FFFF, 32'd5);
  endtask

  task automatic t_quiet;
    apply("R6", 3'b001, 32'h7FFF_FFFF, 32'd1);
    apply("R6", 3'b011, 32'h8000_0000, 32'd1);
    apply("R6", 3'b100, 32'h8000_0000, 32'd1);
    apply("R6", 3'b101, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare;
    apply("R7", 3'b100, 32'hFFFF_FFFC, 32'd10);
    apply("R8", 3'b101, 32'hFFFF_FFFC, 32'd10);
    apply("R7", 3'b100, 32'h7FFF_FFFF, 32'h8000_0000);
    apply("R7", 3'b100, 32'h8000_0000, 32'h7FFF_FFFF);
    apply("R7", 3'b100, 32'd6, 32'd6);
    apply("R8", 3'b101, 32'd6, 32'd7);
    apply("R8", 3'b101, 32'd7, 32'd7);
    apply("R8", 3'b101, 32'h0000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_unused;
    apply("R9", 3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R9", 3'b111, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
  endtask

  task automatic t_sweep;
    logic [31:0] x;
    logic [31:0] y;
    x = 32'h1357_9BDF;
    y = 32'h2468_ACE0;
    for (int i = 0; i < 40; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      y = (y << 3) ^ (y >> 5) ^ x;
      for (int o = 0; o < 8; o++) apply("R1 R2 R7 R8 sweep", 3'(o), x, y);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_quiet();
    t_compare();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule